// File: doc/BRIEF.md
# ADC Result Window Comparator

This block sits beside an ADC sequencer and inspects every converted result as it leaves the converter. Each result arrives with a valid strobe and the number of the analog input it came from. The block tests the result against a programmable low limit and high limit using up to five relations, each switched on separately; a result that meets any switched-on relation counts as a match, provided the comparator is enabled and the input is one of the inputs it is allowed to watch.

A match raises a sticky event flag and records the input number that caused it. The flag stays up, and the recorded number stays frozen, until software reads the recorded number or switches the comparator off. An interrupt request follows the flag whenever the interrupt enable is set. Software reaches the block through a small word-wide register port with four locations: control/status, captured input number, low limit and high limit.

Top module: `adc_win_cmp`

## Requirements
- R1: After reset every register reads zero (control/status, captured input number, both limits) and the interrupt request is low.
- R2: The "inside" relation (control bit 2) matches only when the result is strictly above the low limit and strictly below the high limit.
- R3: The "upper-reached" relation (control bit 3) matches when the result is greater than or equal to the high limit; the "under-upper" relation (control bit 4) matches when the result is strictly below the high limit.
- R4: The "lower-reached" relation (control bit 5) matches when the result is greater than or equal to the low limit; the "under-lower" relation (control bit 6) matches when the result is strictly below the low limit.
- R5: A match is the OR of the switched-on relations; with control bits 6:2 all zero no result ever sets the flag.
- R6: Limits are 16-bit unsigned values held at location 2 (low) and 3 (high), compared zero-extended against the full 32-bit unsigned result, so a result of 65536 or more is above any limit.
- R7: Only input numbers below 8 are watched; results tagged 8 and above (including the reserved codes 0x2B to 0x3F) never set the flag.
- R8: A match while enabled sets the flag (read at location 0, bit 7) in the next cycle and records the input number (location 1, bits 5:0); further matches while the flag is set leave the recorded number unchanged.
- R9: A read of location 1 returns the recorded number and clears the flag in the next cycle.
- R10: A match in the same cycle as a read of location 1 wins: the flag stays set and the new input number is recorded.
- R11: The enable is control bit 0; writing it to zero clears the flag in the next cycle, and no result sets the flag while the comparator is disabled.
- R12: The interrupt request is high exactly when the flag is set and the interrupt enable (control bit 1) is set.
- R13: A result presented with the valid strobe low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | A converted result is presented this cycle |
| res_data | input | 32 | Converted result, unsigned |
| res_id | input | 6 | Analog input number of the result |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect at location 1) |
| reg_addr | input | 2 | Register location: 0 control/status, 1 captured number, 2 low limit, 3 high limit |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the same cycle as the address |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit result, 16-bit limits, a 6-bit input number and eight watched inputs. Because the result is twice as wide as the limits, results above 65535 can be aimed at the truncation error, and with eight watched inputs the numbers 8, 43 and 63 exercise exclusion of ordinary and reserved codes. Limits of 100 and 200 put results at, just below and just above each boundary for all five relations, and a read of the captured number is aligned with a fresh match to reach the same-cycle priority case.

// File: rtl/adc_win_pkg.sv
package adc_win_pkg;

    typedef enum logic [1:0] {
        LOC_CTRL = 2'd0,
        LOC_ID   = 2'd1,
        LOC_LO   = 2'd2,
        LOC_HI   = 2'd3
    } reg_loc_e;

    localparam int N_REL = 5;

    // relation select bits, order matches control bits 6:2
    localparam int REL_INSIDE = 0;
    localparam int REL_UP_GE  = 1;
    localparam int REL_UP_LT  = 2;
    localparam int REL_LO_GE  = 3;
    localparam int REL_LO_LT  = 4;

    typedef struct packed {
        logic             en;
        logic             gie;
        logic [N_REL-1:0] rel;
    } ctrl_t;

endpackage

// File: rtl/adc_win_rel.sv
module adc_win_rel
    import adc_win_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LIM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data,
    input  logic [LIM_W-1:0]  lim_lo,
    input  logic [LIM_W-1:0]  lim_hi,
    input  logic [N_REL-1:0]  rel_en,
    output logic              hit
);
    localparam int PAD_W = DATA_W - LIM_W;

    logic [DATA_W-1:0] lo_ext;
    logic [DATA_W-1:0] hi_ext;
    logic [N_REL-1:0]  rel_true;
    logic [N_REL-1:0]  rel_sel;

    assign lo_ext = {{PAD_W{1'b0}}, lim_lo};
    assign hi_ext = {{PAD_W{1'b0}}, lim_hi};

    always_comb begin
        rel_true             = '0;
        rel_true[REL_INSIDE] = (data > lo_ext) && (data < hi_ext);
        rel_true[REL_UP_GE]  = (data >= hi_ext);
        rel_true[REL_UP_LT]  = (data < hi_ext);
        rel_true[REL_LO_GE]  = (data >= lo_ext);
        rel_true[REL_LO_LT]  = (data < lo_ext);
    end

    for (genvar g = 0; g < N_REL; g++) begin : g_sel
        assign rel_sel[g] = rel_true[g] & rel_en[g];
    end

    assign hit = |rel_sel;

    AST_NO_REL_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_en == '0) |-> !hit); // R5

endmodule

// File: rtl/adc_win_gate.sv
module adc_win_gate #(
    parameter int ID_W      = 6,
    parameter int MON_COUNT = 8
) (
    input  logic            valid,
    input  logic            enabled,
    input  logic [ID_W-1:0] id,
    input  logic            rel_hit,
    output logic            take
);
    localparam logic [ID_W:0] MON_LIM = MON_COUNT[ID_W:0];

    logic watched;

    assign watched = ({1'b0, id} < MON_LIM);
    assign take    = valid && enabled && watched && rel_hit;

endmodule

// File: rtl/adc_win_rdmux.sv
module adc_win_rdmux
    import adc_win_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int ID_W  = 6,
    parameter int LIM_W = 16
) (
    input  logic [1:0]       addr,
    input  ctrl_t            ctrl,
    input  logic             flag,
    input  logic [ID_W-1:0]  id,
    input  logic [LIM_W-1:0] lim_lo,
    input  logic [LIM_W-1:0] lim_hi,
    output logic [REG_W-1:0] rdata
);
    localparam int CTRL_W = 3 + N_REL;

    always_comb begin
        rdata = '0;
        unique case (reg_loc_e'(addr))
            LOC_CTRL: rdata[CTRL_W-1:0] = {flag, ctrl.rel, ctrl.gie, ctrl.en};
            LOC_ID:   rdata[ID_W-1:0]   = id;
            LOC_LO:   rdata[LIM_W-1:0]  = lim_lo;
            LOC_HI:   rdata[LIM_W-1:0]  = lim_hi;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/adc_win_cmp.sv
module adc_win_cmp
    import adc_win_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LIM_W     = 16,
    parameter int ID_W      = 6,
    parameter int MON_COUNT = 8,
    parameter int REG_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [ID_W-1:0]   res_id,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    localparam int CTRL_W = 2 + N_REL;

    typedef struct packed {
        ctrl_t            ctrl;
        logic             flag;
        logic [ID_W-1:0]  id;
        logic [LIM_W-1:0] lo;
        logic [LIM_W-1:0] hi;
    } state_t;

    state_t st_q;
    state_t st_d;

    logic rel_hit;
    logic take;
    logic id_read;
    logic ctl_wr;
    logic unused_wbits;

    assign unused_wbits = ^reg_wdata[REG_W-1:CTRL_W];
    assign id_read = reg_rd && (reg_loc_e'(reg_addr) == LOC_ID);
    assign ctl_wr  = reg_wr && (reg_loc_e'(reg_addr) == LOC_CTRL);

    adc_win_rel #(
        .DATA_W (DATA_W),
        .LIM_W  (LIM_W)
    ) u_rel (
        .clk    (clk),
        .rst_n  (rst_n),
        .data   (res_data),
        .lim_lo (st_q.lo),
        .lim_hi (st_q.hi),
        .rel_en (st_q.ctrl.rel),
        .hit    (rel_hit)
    );

    adc_win_gate #(
        .ID_W      (ID_W),
        .MON_COUNT (MON_COUNT)
    ) u_gate (
        .valid   (res_valid),
        .enabled (st_q.ctrl.en),
        .id      (res_id),
        .rel_hit (rel_hit),
        .take    (take)
    );

    adc_win_rdmux #(
        .REG_W (REG_W),
        .ID_W  (ID_W),
        .LIM_W (LIM_W)
    ) u_rdmux (
        .addr   (reg_addr),
        .ctrl   (st_q.ctrl),
        .flag   (st_q.flag),
        .id     (st_q.id),
        .lim_lo (st_q.lo),
        .lim_hi (st_q.hi),
        .rdata  (reg_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            unique case (reg_loc_e'(reg_addr))
                LOC_CTRL: begin
                    st_d.ctrl.en  = reg_wdata[0];
                    st_d.ctrl.gie = reg_wdata[1];
                    st_d.ctrl.rel = reg_wdata[CTRL_W-1:2];
                end
                LOC_LO:  st_d.lo = reg_wdata[LIM_W-1:0];
                LOC_HI:  st_d.hi = reg_wdata[LIM_W-1:0];
                default: ;
            endcase
        end
        if (!st_d.ctrl.en) begin
            st_d.flag = 1'b0;
        end else if (take) begin
            st_d.flag = 1'b1;
            if (!st_q.flag || id_read) begin
                st_d.id = res_id;
            end
        end else if (id_read) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.flag && st_q.ctrl.gie;

    AST_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.en |-> !st_q.flag); // R11

    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !(ctl_wr && !reg_wdata[0])) |=> st_q.flag); // R8

    AST_ID_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !id_read) |=> $stable(st_q.id)); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (id_read && !take) |=> !st_q.flag); // R9

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_q.flag && st_q.ctrl.gie)); // R12

endmodule

// File: tb/tb_adc_win_cmp.sv
`timescale 1ns/1ps
module tb_adc_win_cmp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [31:0] res_data = '0;
    logic [5:0]  res_id = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] last_rd;

    // reference state
    bit        m_en, m_gie, m_flag;
    bit [4:0]  m_rel;
    bit [5:0]  m_id;
    bit [15:0] m_lo, m_hi;

    always #2.5 clk = ~clk;

    adc_win_cmp dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_id    (res_id),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return {24'b0, m_flag, m_rel, m_gie, m_en};
            2'd1: return {26'b0, m_id};
            2'd2: return {16'b0, m_lo};
            default: return {16'b0, m_hi};
        endcase
    endfunction

    function automatic bit model_take(input bit v, input logic [31:0] d, input logic [5:0] id);
        int unsigned dv, lo, hi;
        bit [4:0] r;
        dv = d; lo = m_lo; hi = m_hi;
        r[0] = (dv > lo) && (dv < hi);
        r[1] = dv >= hi;
        r[2] = dv < hi;
        r[3] = dv >= lo;
        r[4] = dv < lo;
        return m_en && v && (id < 8) && ((r & m_rel) != 0);
    endfunction

    // one clock: drive, compare against the model, then advance the model
    task automatic cyc(input bit wr, input bit rd, input logic [1:0] a, input logic [31:0] wd,
                       input bit v, input logic [31:0] d, input logic [5:0] id, input string tag);
        bit tk, idrd, en_n;
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        res_valid = v; res_data = d; res_id = id;
        #1;
        last_rd = reg_rdata;
        check({tag, " rdata"}, reg_rdata, model_read(a));
        check("R12 irq", {31'b0, irq}, {31'b0, m_flag && m_gie});
        @(posedge clk);
        tk   = model_take(v, d, id);
        idrd = rd && (a == 2'd1);
        en_n = (wr && a == 2'd0) ? wd[0] : m_en;
        if (!en_n) m_flag = 0;
        else if (tk) begin
            if (!m_flag || idrd) m_id = id;
            m_flag = 1;
        end else if (idrd) m_flag = 0;
        if (wr) begin
            case (a)
                2'd0: begin m_en = wd[0]; m_gie = wd[1]; m_rel = wd[6:2]; end
                2'd2: m_lo = wd[15:0];
                2'd3: m_hi = wd[15:0];
                default: ;
            endcase
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
        cyc(1, 0, a, d, 0, 0, 0, tag);
    endtask
    task automatic rd(input logic [1:0] a, input string tag);
        cyc(0, 1, a, 0, 0, 0, 0, tag);
    endtask
    task automatic res(input logic [31:0] d, input logic [5:0] id, input string tag);
        cyc(0, 0, 2'd0, 0, 1, d, id, tag);
    endtask
    task automatic flag_is(input bit exp, input string tag);
        rd(2'd0, tag);
        check({tag, " flag"}, {31'b0, last_rd[7]}, {31'b0, exp});
    endtask
    task automatic id_is(input logic [5:0] exp, input string tag);
        rd(2'd1, tag);
        check({tag, " id"}, last_rd, {26'b0, exp});
    endtask

    initial begin
        #50000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog timeout actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset values
        check("R1 irq", {31'b0, irq}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            rd(i[1:0], "R1");
            check("R1 reset", last_rd, 32'd0);
        end
        wr(2'd2, 32'd100, "R6");
        wr(2'd3, 32'd200, "R6");

        // R2 inside, strict at both ends
        wr(2'd0, 32'h05, "R2");
        res(100, 1, "R2"); res(200, 1, "R2");
        flag_is(0, "R2");
        res(150, 3, "R2");
        flag_is(1, "R2");
        // R8 a later match does not overwrite
        res(160, 5, "R8");
        id_is(3, "R9");
        flag_is(0, "R9");

        // R3
        wr(2'd0, 32'h09, "R3");
        res(199, 1, "R3"); flag_is(0, "R3");
        res(200, 2, "R3"); id_is(2, "R3");
        wr(2'd0, 32'h11, "R3");
        res(200, 1, "R3"); flag_is(0, "R3");
        res(199, 4, "R3"); id_is(4, "R3");

        // R4
        wr(2'd0, 32'h21, "R4");
        res(99, 1, "R4"); flag_is(0, "R4");
        res(100, 5, "R4"); id_is(5, "R4");
        wr(2'd0, 32'h41, "R4");
        res(100, 1, "R4"); flag_is(0, "R4");
        res(99, 6, "R4"); id_is(6, "R4");

        // R6 full-width result
        wr(2'd0, 32'h41, "R6");
        res(32'h0001_0032, 2, "R6"); flag_is(0, "R6");
        wr(2'd0, 32'h09, "R6");
        res(32'h0001_0000, 6, "R6"); id_is(6, "R6");

        // R5 no relation selected, then OR of two
        wr(2'd0, 32'h01, "R5");
        res(50, 1, "R5"); res(150, 1, "R5"); res(250, 1, "R5");
        flag_is(0, "R5");
        wr(2'd0, 32'h49, "R5");
        res(150, 1, "R5"); flag_is(0, "R5");
        res(250, 0, "R5"); id_is(0, "R5");
        res(50, 7, "R5"); id_is(7, "R5");

        // R7 watched inputs only
        wr(2'd0, 32'h21, "R7");
        res(150, 8, "R7"); res(150, 43, "R7"); res(150, 63, "R7");
        flag_is(0, "R7");
        res(150, 7, "R7"); flag_is(1, "R7");

        // R10 match in the same cycle as the clearing read
        cyc(0, 1, 2'd1, 0, 1, 150, 2, "R10");
        check("R10 old id", last_rd, 32'd7);
        flag_is(1, "R10");
        id_is(2, "R10");
        flag_is(0, "R10");

        // R11 disable clears, no events while off
        res(150, 3, "R11"); flag_is(1, "R11");
        wr(2'd0, 32'h20, "R11");
        flag_is(0, "R11");
        res(150, 4, "R11"); flag_is(0, "R11");
        wr(2'd0, 32'h21, "R11");
        flag_is(0, "R11");
        id_is(3, "R11");

        // R12 interrupt
        wr(2'd0, 32'h23, "R12");
        res(150, 1, "R12");
        rd(2'd0, "R12");
        check("R12 irq high", {31'b0, irq}, 32'd1);
        wr(2'd0, 32'h21, "R12");
        rd(2'd0, "R12");
        check("R12 irq masked", {31'b0, irq}, 32'd0);
        id_is(1, "R12");

        // R13 valid low ignored
        cyc(0, 0, 2'd0, 0, 0, 150, 2, "R13");
        flag_is(0, "R13");
        id_is(1, "R13");

        repeat (3) cyc(0, 0, 2'd0, 0, 0, 0, 0, "R1");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule